// File: doc/BRIEF.md
# Banked External Interrupt Router

This block gathers peripheral interrupt lines, grouped in banks of 32, and steers each one to one of several per-thread CPU trigger outputs. Every line has a sense bit that selects edge or level behaviour, an enable bit, a status bit and a small routing code. Each trigger output is high while any enabled line with a set status bit is routed to that thread.

Software works through a simple memory-mapped register port with a single-cycle write strobe and a combinational read. Writing a 1 to a status bit toggles it. Software uses this to acknowledge an edge event, or to raise a fresh 0-to-1 transition that retriggers the CPU. The number of banks is a parameter from 1 to 4, giving 32 to 128 lines.

Top module: `ext_irq_router`

## Requirements
- R1: After reset, every status, sense, enable and routing register reads 0 and every trigger output is 0.
- R2: Line n lives in bank n/32 at bit n%32. Register addresses are as follows. Status is at 0x000+8*b, sense at 0x100+8*b and enable at 0x200+8*b. The routing code of a line is at 0x1000*(b+1)+4*(n%32), in bits [3:0]. Any other address reads 0, and a write to it changes nothing.
- R3: Each input passes through a two-flop synchroniser. If an edge line's input goes high between two clock edges, its status bit is set on the third rising edge after that, and its trigger output rises one edge later.
- R4: A rising edge on the input of an edge-sensed line (sense bit 0) sets its status bit. The bit stays set after the input falls.
- R5: For an edge line, a write with bit i = 1 to its status register toggles status bit i. This clears a set bit (acknowledge) and sets a clear bit (retrigger). Bits written 0 are unchanged.
- R6: If a synchronised rising edge and a write of 1 reach the same edge-line status bit in the same cycle, the bit ends up set.
- R7: For a level-sensed line (sense bit 1), the status bit follows the synchronised input. A write of 1 forces it to 0 for one cycle, after which it follows the input again, which gives a fresh 0-to-1 transition.
- R8: Enable bit 1 lets a line drive triggers. With enable 0 the line drives no trigger output, but its status bit still records events.
- R9: A routing code of 0 disconnects a line. Code t+1 routes it to trig_out[t]. Codes above the thread count disconnect it. trig_out[t] is registered and equals the OR of enabled, set, routed lines one cycle earlier.
- R10: Registers of banks at or above NUM_BANKS read 0, and writes to them affect no implemented bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Asynchronous peripheral interrupt lines |
| reg_addr | input | 16 | Register byte address |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| trig_out | output | NUM_THREADS | Per-thread trigger outputs |

## Verification
The assertions check four things on every cycle. No trigger fires while every enable bit is 0 or every routing code is 0. An edge-sensed status bit never clears except after a write. Addresses of missing banks always read 0. The exact synchroniser latency, toggle and acknowledge semantics, the edge-versus-write collision and the one-cycle dip of a level retrigger are only visible in the bench's timed scenarios. The same holds for routing to the correct thread for each code.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int BANK_LINES = 32;
    localparam int LINE_W     = 5;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int MAX_BANKS  = 4;
    localparam int BANK_W     = 2;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STATUS,
        RK_SENSE,
        RK_ENABLE,
        RK_ROUTE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BANK_W-1:0]  bank;
        logic [LINE_W-1:0]  line;
    } reg_sel_t;

    // Map a byte address onto register kind, bank and line.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t   s;
        logic [3:0] blk;
        s.kind = RK_NONE;
        s.bank = a[4:3];
        s.line = a[6:2];
        blk    = a[15:12] - 4'd1;
        if (a[15:12] == 4'd0) begin
            if (a[11:10] == 2'd0 && a[7:5] == 3'd0 && a[2:0] == 3'd0) begin
                case (a[9:8])
                    2'd0:    s.kind = RK_STATUS;
                    2'd1:    s.kind = RK_SENSE;
                    2'd2:    s.kind = RK_ENABLE;
                    default: s.kind = RK_NONE;
                endcase
            end
        end else if (a[15:12] <= 4'(MAX_BANKS) && a[11:7] == 5'd0 && a[1:0] == 2'd0) begin
            s.kind = RK_ROUTE;
            s.bank = blk[BANK_W-1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/ext_irq_bank.sv
module ext_irq_bank
    import ext_irq_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int VEC_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BANK_LINES-1:0]   irq_sync,
    input  logic                    wr_en,
    input  reg_kind_e               sel_kind,
    input  logic [LINE_W-1:0]       sel_line,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NUM_THREADS-1:0]  hits,
    output logic [BANK_LINES-1:0]   status_o,
    output logic [BANK_LINES-1:0]   sense_o,
    output logic [BANK_LINES-1:0]   enable_o,
    output logic                    route_any_o
);

    localparam int BL = BANK_LINES;

    typedef struct packed {
        logic [BL-1:0]       status;
        logic [BL-1:0]       sense;
        logic [BL-1:0]       enable;
        logic [BL-1:0]       prev;
        logic [BL*VEC_W-1:0] route;
    } bank_st_t;

    bank_st_t      st_d, st_q;
    logic [BL-1:0] rise;
    logic [BL-1:0] toggle;

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_sync;
        rise      = irq_sync & ~st_q.prev;
        toggle    = (wr_en && sel_kind == RK_STATUS) ? wr_data : '0;
        for (int i = 0; i < BL; i++) begin
            if (st_q.sense[i]) begin
                // level: follow input, a written 1 drops it for one cycle
                st_d.status[i] = irq_sync[i] & ~toggle[i];
            end else begin
                // edge: capture wins over a simultaneous toggle
                st_d.status[i] = rise[i] | (st_q.status[i] ^ toggle[i]);
            end
        end
        if (wr_en) begin
            case (sel_kind)
                RK_SENSE:  st_d.sense  = wr_data;
                RK_ENABLE: st_d.enable = wr_data;
                RK_ROUTE:  st_d.route[sel_line*VEC_W +: VEC_W] = wr_data[VEC_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Per-thread request: enabled, pending and routed to that thread.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            hits[t] = 1'b0;
            for (int i = 0; i < BL; i++) begin
                if (st_q.status[i] && st_q.enable[i] &&
                    st_q.route[i*VEC_W +: VEC_W] == VEC_W'(t + 1)) begin
                    hits[t] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (sel_kind)
            RK_STATUS: rd_data = st_q.status;
            RK_SENSE:  rd_data = st_q.sense;
            RK_ENABLE: rd_data = st_q.enable;
            RK_ROUTE:  rd_data = DATA_W'(st_q.route[sel_line*VEC_W +: VEC_W]);
            default:   rd_data = '0;
        endcase
    end

    assign status_o    = st_q.status;
    assign sense_o     = st_q.sense;
    assign enable_o    = st_q.enable;
    assign route_any_o = |st_q.route;

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import ext_irq_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int NUM_THREADS = 4,
    parameter int VEC_W       = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*32-1:0]       irq_in,
    input  logic [15:0]                   reg_addr,
    input  logic                          reg_wen,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic [NUM_THREADS-1:0]        trig_out
);

    localparam int LINES = NUM_BANKS * BANK_LINES;

    typedef struct packed {
        logic [NUM_THREADS-1:0] trig;
    } top_st_t;

    top_st_t              st_d, st_q;
    reg_sel_t             sel;
    logic                 bank_ok;
    logic [LINES-1:0]     irq_sync;
    logic [LINES-1:0]     status_all;
    logic [LINES-1:0]     sense_all;
    logic [LINES-1:0]     enable_all;
    logic [NUM_BANKS-1:0] route_any_b;
    logic                 route_any;
    logic [DATA_W-1:0]    bank_rd  [NUM_BANKS];
    logic [NUM_THREADS-1:0] bank_hit [NUM_BANKS];

    assign sel     = decode_addr(reg_addr);
    assign bank_ok = (int'(sel.bank) < NUM_BANKS) && (sel.kind != RK_NONE);

    ext_irq_sync #(.WIDTH(LINES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (irq_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_here;
        assign wr_here = reg_wen && bank_ok && (sel.bank == BANK_W'(b));

        ext_irq_bank #(
            .NUM_THREADS (NUM_THREADS),
            .VEC_W       (VEC_W)
        ) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .irq_sync    (irq_sync[b*BANK_LINES +: BANK_LINES]),
            .wr_en       (wr_here),
            .sel_kind    (sel.kind),
            .sel_line    (sel.line),
            .wr_data     (reg_wdata),
            .rd_data     (bank_rd[b]),
            .hits        (bank_hit[b]),
            .status_o    (status_all[b*BANK_LINES +: BANK_LINES]),
            .sense_o     (sense_all[b*BANK_LINES +: BANK_LINES]),
            .enable_o    (enable_all[b*BANK_LINES +: BANK_LINES]),
            .route_any_o (route_any_b[b])
        );
    end

    assign route_any = |route_any_b;

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_ok && sel.bank == BANK_W'(b)) reg_rdata = bank_rd[b];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.trig = '0;
        for (int b = 0; b < NUM_BANKS; b++) st_d.trig = st_d.trig | bank_hit[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_out = st_q.trig;

endmodule

// File: rtl/ext_irq_router_chk.sv
module ext_irq_router_chk #(
    parameter int NUM_BANKS   = 2,
    parameter int NUM_THREADS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [15:0]             reg_addr,
    input logic                    reg_wen,
    input logic [31:0]             reg_rdata,
    input logic [NUM_THREADS-1:0]  trig_out,
    input logic [NUM_BANKS*32-1:0] status_all,
    input logic [NUM_BANKS*32-1:0] sense_all,
    input logic [NUM_BANKS*32-1:0] enable_all,
    input logic                    route_any
);

    // R8: with every line disabled no trigger may fire next cycle
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_all == '0) |=> (trig_out == '0));

    // R9: with every routing code at 0 no trigger may fire next cycle
    a_r9_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_any) |=> (trig_out == '0));

    // R4: an edge-sensed status bit only clears after a write
    a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wen) |=> (($past(status_all) & ~status_all & ~sense_all) == '0));

    // R10: status/sense/enable of a missing bank read 0
    a_r10_missing_grp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[15:12] == 4'd0 && int'(reg_addr[4:3]) >= NUM_BANKS) |-> (reg_rdata == '0));

    // R10: routing codes of a missing bank read 0
    a_r10_missing_route_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr[15:12]) > NUM_BANKS) |-> (reg_rdata == '0));

endmodule

bind ext_irq_router ext_irq_router_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .NUM_THREADS (NUM_THREADS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wen    (reg_wen),
    .reg_rdata  (reg_rdata),
    .trig_out   (trig_out),
    .status_all (status_all),
    .sense_all  (sense_all),
    .enable_all (enable_all),
    .route_any  (route_any)
);

// File: tb/ext_irq_router_tb_top.sv
`timescale 1ns/1ps
module ext_irq_router_tb_top;

    localparam int NB = 2;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] irq_in = '0;
    logic [15:0]   reg_addr = '0;
    logic          reg_wen = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NT-1:0] trig_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ext_irq_router #(.NUM_BANKS(NB), .NUM_THREADS(NT), .VEC_W(4)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .trig_out  (trig_out)
    );

    typedef struct packed {
        logic [6:0] line;
        logic       lvl;
        logic [3:0] code;
        logic       en;
        logic [3:0] exp_trig;
    } vec_t;

    localparam vec_t TABLE [7] = '{
        '{line: 7'd0,  lvl: 1'b0, code: 4'd1, en: 1'b1, exp_trig: 4'b0001},
        '{line: 7'd37, lvl: 1'b1, code: 4'd3, en: 1'b1, exp_trig: 4'b0100},
        '{line: 7'd31, lvl: 1'b0, code: 4'd4, en: 1'b1, exp_trig: 4'b1000},
        '{line: 7'd12, lvl: 1'b0, code: 4'd2, en: 1'b0, exp_trig: 4'b0000},
        '{line: 7'd50, lvl: 1'b1, code: 4'd0, en: 1'b1, exp_trig: 4'b0000},
        '{line: 7'd63, lvl: 1'b0, code: 4'd7, en: 1'b1, exp_trig: 4'b0000},
        '{line: 7'd33, lvl: 1'b1, code: 4'd2, en: 1'b1, exp_trig: 4'b0010}
    };

    function automatic logic [15:0] a_stat(input int b);  return 16'(8 * b);        endfunction
    function automatic logic [15:0] a_sense(input int b); return 16'(256 + 8 * b);  endfunction
    function automatic logic [15:0] a_en(input int b);    return 16'(512 + 8 * b);  endfunction
    function automatic logic [15:0] a_route(input int n);
        return 16'(4096 * (n / 32 + 1) + 4 * (n % 32));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk("R1", "trig after reset", 32'(trig_out), 32'h0);
        rd(a_stat(0), v);   chk("R1", "status b0", v, 32'h0);
        rd(a_sense(1), v);  chk("R1", "sense b1", v, 32'h0);
        rd(a_en(0), v);     chk("R1", "enable b0", v, 32'h0);
        rd(a_route(45), v); chk("R1", "route line45", v, 32'h0);

        // R2: address map and field positions
        wr(a_en(0), 32'hA5A5_A5A5);
        rd(a_en(0), v);     chk("R2", "enable b0 readback", v, 32'hA5A5_A5A5);
        rd(a_en(1), v);     chk("R2", "enable b1 untouched", v, 32'h0);
        wr(a_route(45), 32'hFFFF_FFF9);
        wr(a_route(44), 32'h3);
        rd(a_route(45), v); chk("R2", "route line45 field", v, 32'h9);
        rd(a_route(44), v); chk("R2", "route line44 field", v, 32'h3);
        wr(16'h0300, 32'hFFFF_FFFF);
        rd(16'h0300, v);    chk("R2", "hole reads zero", v, 32'h0);
        wr(a_en(0), 32'h0);
        wr(a_route(45), 32'h0);
        wr(a_route(44), 32'h0);

        // R10: missing banks
        wr(a_en(3), 32'hFFFF_FFFF);
        rd(a_en(3), v);     chk("R10", "missing bank enable", v, 32'h0);
        rd(a_en(1), v);     chk("R10", "bank1 not aliased", v, 32'h0);
        wr(a_route(100), 32'h2);
        rd(a_route(100), v); chk("R10", "missing bank route", v, 32'h0);
        rd(a_route(36), v);  chk("R10", "route not aliased", v, 32'h0);

        // Table walk: R4 R7 R8 R9
        foreach (TABLE[e]) begin
            automatic int n  = int'(TABLE[e].line);
            automatic int b  = n / 32;
            automatic logic [31:0] bm = 32'h1 << (n % 32);
            wr(a_sense(b), TABLE[e].lvl ? bm : 32'h0);
            wr(a_en(b), TABLE[e].en ? bm : 32'h0);
            wr(a_route(n), 32'(TABLE[e].code));
            irq_in[n] = 1'b1;
            idle(6);
            chk("R9", $sformatf("trig for line %0d", n), 32'(trig_out), 32'(TABLE[e].exp_trig));
            rd(a_stat(b), v);
            chk("R8", $sformatf("status recorded line %0d", n), v & bm, bm);
            irq_in[n] = 1'b0;
            idle(6);
            rd(a_stat(b), v);
            if (TABLE[e].lvl) begin
                chk("R7", $sformatf("level follows line %0d", n), v & bm, 32'h0);
            end else begin
                chk("R4", $sformatf("edge holds line %0d", n), v & bm, bm);
                wr(a_stat(b), bm);
                rd(a_stat(b), v);
                chk("R5", $sformatf("ack clears line %0d", n), v & bm, 32'h0);
            end
            wr(a_route(n), 32'h0);
            wr(a_en(b), 32'h0);
            wr(a_sense(b), 32'h0);
            idle(3);
            chk("R9", $sformatf("trig idle after line %0d", n), 32'(trig_out), 32'h0);
        end

        // R3: synchroniser latency on line 1 (edge, thread 0)
        wr(a_en(0), 32'h2);
        wr(a_route(1), 32'h1);
        reg_addr = a_stat(0);
        irq_in[1] = 1'b1;
        @(negedge clk); #1; chk("R3", "status after 1 edge", reg_rdata & 32'h2, 32'h0);
        @(negedge clk); #1; chk("R3", "status after 2 edges", reg_rdata & 32'h2, 32'h0);
        @(negedge clk); #1; chk("R3", "status after 3 edges", reg_rdata & 32'h2, 32'h2);
        chk("R3", "trig after 3 edges", 32'(trig_out), 32'h0);
        @(negedge clk);     chk("R3", "trig after 4 edges", 32'(trig_out), 32'h1);
        irq_in[1] = 1'b0;
        idle(3);
        wr(a_stat(0), 32'h2);
        idle(2);
        chk("R5", "trig drops after ack", 32'(trig_out), 32'h0);

        // R5: toggle semantics on line 3 (edge, thread 1), input low
        wr(a_en(0), 32'h8);
        wr(a_route(3), 32'h2);
        wr(a_stat(0), 32'h8);
        rd(a_stat(0), v);   chk("R5", "write1 sets clear bit", v, 32'h8);
        chk("R5", "retrigger reaches thread1", 32'(trig_out), 32'h2);
        wr(a_stat(0), 32'h0);
        rd(a_stat(0), v);   chk("R5", "write0 no effect", v, 32'h8);

        // R6: edge arrives in the same cycle as a clearing write
        irq_in[3] = 1'b1;
        idle(2);
        wr(a_stat(0), 32'h8);
        rd(a_stat(0), v);   chk("R6", "edge beats toggle", v, 32'h8);
        irq_in[3] = 1'b0;
        idle(3);
        wr(a_stat(0), 32'h8);
        rd(a_stat(0), v);   chk("R5", "final ack line3", v, 32'h0);
        wr(a_en(0), 32'h0);
        wr(a_route(3), 32'h0);

        // R7: level retrigger on line 40 (bank1 bit8, thread 1)
        wr(a_sense(1), 32'h100);
        wr(a_en(1), 32'h100);
        wr(a_route(40), 32'h2);
        irq_in[40] = 1'b1;
        idle(6);
        chk("R7", "level trig high", 32'(trig_out), 32'h2);
        wr(a_stat(1), 32'h100);
        rd(a_stat(1), v);   chk("R7", "write1 drops level status", v, 32'h0);
        chk("R7", "trig dips", 32'(trig_out), 32'h0);
        rd(a_stat(1), v);   chk("R7", "level status returns", v, 32'h100);
        chk("R7", "trig re-raised", 32'(trig_out), 32'h2);
        irq_in[40] = 1'b0;
        idle(4);
        chk("R7", "trig low after input drop", 32'(trig_out), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule